// File: doc/BRIEF.md
# Serial flash command decoder with sector protection

This block sits behind the serial pins of a 512 KB NOR-style memory built from eight 64 KB sectors. It oversamples chip select, serial clock and serial data with the system clock. It assembles command, address and data bytes, and turns complete commands into one-cycle strobes on a simple memory-array port: read, program and erase. Read data and status come back to the host on the serial output line. The block owns a small status register. That register holds a busy flag, a write-enable latch and a three-bit protection code.

Commands that change state are guarded in four ways. They must end on a whole byte. They need the write-enable latch set. They may not start while a previous change is still in progress. Program and erase must also miss the protected upper region of the array. A fixed, parameterised count of system clocks stands in for the array operation time. During that time only the status read is honoured.

Top module: `spi_flash_frontend`

## Requirements
- R1: A command begins when cs_n goes low. The block samples di on each rising sck edge, MSB first, and the first 8 bits form the opcode.
- R2: Opcode 05h shifts out the status byte MSB first on do_o, changing after falling sck edges. It repeats that byte while cs_n stays low. The byte layout is bit 0 busy, bit 1 write-enable latch, bits 4:2 the protection code, and bits 7:5 zero.
- R3: Opcode 03h takes a 24-bit address, of which only the low 19 bits are used. It pulses mem_rd, then streams bytes from consecutive addresses, wrapping at the top of the array. It may be ended after any bit.
- R4: Opcode 06h sets the write-enable latch and opcode 04h clears it.
- R5: Opcodes 06h, 04h, 01h, 02h and D8h act only if cs_n rises after a whole number of bytes. Otherwise the command is dropped with no strobe, and the latch keeps its value.
- R6: Program, erase and status write are ignored when the write-enable latch is clear.
- R7: Opcode 02h with a 3-byte address and at least one data byte gives one mem_prog pulse after cs_n rises. The pulse carries the address and the last complete data byte.
- R8: Opcode D8h with a 3-byte address gives one mem_erase pulse after cs_n rises. The pulse carries the address, and its bits 18:16 name the sector.
- R9: Opcode 01h loads bits 4:2 of its last complete data byte into the protection code.
- R10: An accepted program, erase or status write holds busy for BUSY_CYCLES clocks, starting in the strobe cycle. When busy ends, the write-enable latch clears.
- R11: While busy is set at opcode completion, every opcode except 05h is ignored for the rest of that command.
- R12: The protection code selects the protected region. Code 0 protects nothing, 1 protects 70000h-7FFFFh, 2 protects 60000h-7FFFFh, 3 protects 40000h-7FFFFh, and codes 4 to 7 protect everything. A program or erase aimed at a protected address gives no strobe, clears the latch and leaves busy at 0.
- R13: After reset, busy, the latch and the protection code are 0 and no strobe is active. do_o is 0 whenever no data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data to the host |
| mem_rd | output | 1 | One-cycle read request |
| mem_prog | output | 1 | One-cycle program request |
| mem_erase | output | 1 | One-cycle sector erase request |
| mem_addr | output | ADDR_W | Byte address for the active request |
| mem_wdata | output | 8 | Byte to program |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
The bench keeps the default 19-bit address and eight sectors, so a read that starts at 7FFFEh can be seen wrapping to address 0. It sets BUSY_CYCLES to 1500 and drives sck with a 12-clock period. With those values the busy window outlasts a status read of several bytes plus a whole erase or read command. The busy flag can therefore be observed directly, and the lockout can be tested with commands that begin while busy is high. The same values also let the bench walk each protection code with a program or erase on both sides of its boundary.

// File: rtl/sff_pkg.sv
package sff_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'hD8;

    typedef enum logic [1:0] {
        TX_NONE = 2'd0,
        TX_STAT = 2'd1,
        TX_DATA = 2'd2
    } tx_mode_e;

endpackage

// File: rtl/sff_sync.sv
module sff_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/sff_prot.sv
module sff_prot #(
    parameter int SECT_W = 3
) (
    input  logic [2:0]        bp,
    input  logic [SECT_W-1:0] sector,
    output logic              prot
);
    localparam int NSECT = 1 << SECT_W;

    logic [SECT_W:0] span;
    logic [SECT_W:0] lim;

    always_comb begin
        prot = 1'b0;
        span = '0;
        lim  = '0;
        if (bp[2]) begin
            prot = 1'b1;
        end else if (bp[1:0] != 2'd0) begin
            span = (SECT_W+1)'(NSECT >> (4 - int'(bp[1:0])));
            lim  = (SECT_W+1)'(NSECT) - span;
            prot = ({1'b0, sector} >= lim);
        end
    end

endmodule

// File: rtl/sff_status.sv
module sff_status #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       start,
    input  logic       bp_we,
    input  logic [2:0] bp_wdata,
    output logic       busy,
    output logic       wel,
    output logic [2:0] bp
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             wel;
        logic [2:0]       bp;
        logic [CNT_W-1:0] cnt;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d = q;
        if (set_wel) d.wel = 1'b1;
        if (clr_wel) d.wel = 1'b0;
        if (bp_we)   d.bp  = bp_wdata;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(BUSY_CYCLES - 1);
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign wel  = q.wel;
    assign bp   = q.bp;

    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

    // R10
    busy_end_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);

endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend
    import sff_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SECT_W      = 3,
    parameter int BUSY_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              di,
    output logic              do_o,
    output logic              mem_rd,
    output logic              mem_prog,
    output logic              mem_erase,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam logic [2:0] HDR_BYTES  = 3'd4;
    localparam logic [2:0] PROG_BYTES = 3'd5;
    localparam logic [2:0] WRSR_BYTES = 3'd2;

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic [2:0]        bit_idx;
        logic [2:0]        nbytes;
        logic [6:0]        sh_in;
        logic [7:0]        opcode;
        logic              ignore;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        tx_mode_e          tx_mode;
        logic [2:0]        tx_bit;
        logic [7:0]        tx_sh;
        logic              do_bit;
        logic [ADDR_W-1:0] rd_addr;
        logic              rd_pend;
        logic [7:0]        rd_buf;
        logic              rd;
        logic              prog;
        logic              erase;
        logic [ADDR_W-1:0] maddr;
        logic [7:0]        wdata;
    } cmd_t;

    cmd_t d, q;

    logic [2:0] pins_s;
    logic       cs_s, sck_s, di_s;
    logic       busy, wel;
    logic [2:0] bp;
    logic       prot;
    logic       set_wel, clr_wel, start, bp_we;
    logic [2:0] bp_wdata;

    sff_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, di}),
        .dout (pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign di_s  = pins_s[0];

    sff_prot #(.SECT_W(SECT_W)) u_prot (
        .bp    (bp),
        .sector(q.addr[ADDR_W-1 -: SECT_W]),
        .prot  (prot)
    );

    sff_status #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_wel (set_wel),
        .clr_wel (clr_wel),
        .start   (start),
        .bp_we   (bp_we),
        .bp_wdata(bp_wdata),
        .busy    (busy),
        .wel     (wel),
        .bp      (bp)
    );

    logic              cs_rise, sck_rise, sck_fall;
    logic [7:0]        byte_v;
    logic [7:0]        tx_byte;
    logic [ADDR_W-1:0] addr_new;
    logic              ign_new;

    always_comb begin
        d        = q;
        set_wel  = 1'b0;
        clr_wel  = 1'b0;
        start    = 1'b0;
        bp_we    = 1'b0;
        bp_wdata = q.data[4:2];
        byte_v   = {q.sh_in, di_s};
        tx_byte  = '0;
        addr_new = {q.addr[ADDR_W-9:0], byte_v};
        ign_new  = 1'b0;

        cs_rise  = cs_s & ~q.cs_prev;
        sck_rise = sck_s & ~q.sck_prev;
        sck_fall = ~sck_s & q.sck_prev;

        d.cs_prev  = cs_s;
        d.sck_prev = sck_s;
        d.rd       = 1'b0;
        d.prog     = 1'b0;
        d.erase    = 1'b0;
        d.rd_pend  = q.rd;
        if (q.rd_pend) d.rd_buf = mem_rdata;

        if (cs_s) begin
            // end of command: only whole-byte commands take effect
            if (cs_rise && !q.ignore && q.bit_idx == 3'd0) begin
                unique case (q.opcode)
                    OP_WREN: if (q.nbytes != 3'd0) set_wel = 1'b1;
                    OP_WRDI: if (q.nbytes != 3'd0) clr_wel = 1'b1;
                    OP_WRSR: begin
                        if (q.nbytes >= WRSR_BYTES && wel) begin
                            bp_we = 1'b1;
                            start = 1'b1;
                        end
                    end
                    OP_PROG: begin
                        if (q.nbytes >= PROG_BYTES && wel) begin
                            if (prot) begin
                                clr_wel = 1'b1;
                            end else begin
                                d.prog  = 1'b1;
                                d.maddr = q.addr;
                                d.wdata = q.data;
                                start   = 1'b1;
                            end
                        end
                    end
                    OP_ERASE: begin
                        if (q.nbytes >= HDR_BYTES && wel) begin
                            if (prot) begin
                                clr_wel = 1'b1;
                            end else begin
                                d.erase = 1'b1;
                                d.maddr = q.addr;
                                start   = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            d.bit_idx = '0;
            d.nbytes  = '0;
            d.opcode  = '0;
            d.ignore  = 1'b0;
            d.tx_mode = TX_NONE;
            d.tx_bit  = '0;
            d.do_bit  = 1'b0;
        end else begin
            if (sck_rise) begin
                d.sh_in   = byte_v[6:0];
                d.bit_idx = q.bit_idx + 1'b1;
                if (q.bit_idx == 3'd7) begin
                    if (q.nbytes != 3'd7) d.nbytes = q.nbytes + 1'b1;
                    if (q.nbytes == 3'd0) begin
                        ign_new  = busy && (byte_v != OP_RDSR);
                        d.opcode = byte_v;
                        d.ignore = ign_new;
                        if (!ign_new && byte_v == OP_RDSR) begin
                            d.tx_mode = TX_STAT;
                            d.tx_bit  = '0;
                        end
                    end else if (!q.ignore) begin
                        if (q.opcode == OP_WRSR || q.nbytes >= HDR_BYTES) begin
                            d.data = byte_v;
                        end
                        if (q.opcode != OP_WRSR && q.nbytes < HDR_BYTES) begin
                            d.addr = addr_new;
                        end
                        if (q.opcode == OP_READ && q.nbytes == 3'd3) begin
                            d.rd      = 1'b1;
                            d.maddr   = addr_new;
                            d.rd_addr = addr_new;
                            d.tx_mode = TX_DATA;
                            d.tx_bit  = '0;
                        end
                    end
                end
            end
            if (sck_fall && q.tx_mode != TX_NONE) begin
                d.tx_bit = q.tx_bit + 1'b1;
                if (q.tx_bit == 3'd0) begin
                    tx_byte = (q.tx_mode == TX_STAT) ? {3'b000, bp, wel, busy} : q.rd_buf;
                    d.do_bit = tx_byte[7];
                    d.tx_sh  = {tx_byte[6:0], 1'b0};
                    if (q.tx_mode == TX_DATA) begin
                        d.rd_addr = q.rd_addr + 1'b1;
                        d.maddr   = q.rd_addr + 1'b1;
                        d.rd      = 1'b1;
                    end
                end else begin
                    d.do_bit = q.tx_sh[7];
                    d.tx_sh  = {q.tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign do_o      = q.do_bit;
    assign mem_rd    = q.rd;
    assign mem_prog  = q.prog;
    assign mem_erase = q.erase;
    assign mem_addr  = q.maddr;
    assign mem_wdata = q.wdata;

    // R13
    idle_do_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !do_o);

    // R5
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_prog, mem_erase}));

    // R6
    modify_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog || mem_erase) |-> wel);

    // R10
    modify_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog || mem_erase) |-> busy);

    // R12
    all_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog || mem_erase) |-> !bp[2]);

    // R7
    prog_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_prog |-> cs_s);

endmodule

// File: tb/spi_flash_frontend_tb.sv
module spi_flash_frontend_tb_top;

    localparam int BUSY = 1500;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        di = 1'b0;
    logic        do_o;
    logic        mem_rd, mem_prog, mem_erase;
    logic [18:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    always #5 clk = ~clk;

    spi_flash_frontend #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .di       (di),
        .do_o     (do_o),
        .mem_rd   (mem_rd),
        .mem_prog (mem_prog),
        .mem_erase(mem_erase),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b0};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural model
    typedef struct { bit er; logic [18:0] a; logic [7:0] d; } exp_t;
    exp_t        q_exp[$];
    exp_t        e_cur;
    bit          m_wel = 0;
    bit          m_busy = 0;
    logic [2:0]  m_bp = 3'd0;

    function automatic bit m_prot(input logic [18:0] a);
        if (m_bp[2]) return 1'b1;
        case (m_bp[1:0])
            2'd1: return a >= 19'h70000;
            2'd2: return a >= 19'h60000;
            2'd3: return a >= 19'h40000;
            default: return 1'b0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && (mem_prog || mem_erase)) begin
            if (q_exp.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R6 R11 R12 unexpected strobe actual=%0h expected=none", mem_addr);
            end else begin
                e_cur = q_exp.pop_front();
                chk(e_cur.er == mem_erase && e_cur.a == mem_addr && (e_cur.er || e_cur.d == mem_wdata),
                    "R7 R8 strobe content", {4'(mem_erase), 1'b0, mem_addr, mem_wdata},
                    {4'(e_cur.er), 1'b0, e_cur.a, e_cur.d});
            end
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        half();
    endtask

    task automatic desel();
        half();
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r);
        r = '0;
        for (int i = 0; i < nb; i++) begin
            di = b[7-i];
            half();
            r[7-i] = do_o;
            sck = 1'b1;
            half();
            sck = 1'b0;
        end
    endtask

    task automatic one(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, 8, r);
        desel();
    endtask

    task automatic wren();
        one(8'h06);
        if (!m_busy) m_wel = 1;
    endtask

    task automatic wrdi();
        one(8'h04);
        if (!m_busy) m_wel = 0;
    endtask

    task automatic rdsr(input int n, input string req);
        logic [7:0] r;
        logic [7:0] exp;
        sel();
        xfer(8'h05, 8, r);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, r);
            exp = {3'b000, m_bp, m_wel, m_busy};
            chk(r == exp, req, r, exp);
        end
        desel();
    endtask

    task automatic addr3(input logic [23:0] a);
        logic [7:0] r;
        xfer(a[23:16], 8, r);
        xfer(a[15:8], 8, r);
        xfer(a[7:0], 8, r);
    endtask

    task automatic prog(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] r;
        sel();
        xfer(8'h02, 8, r);
        addr3(a);
        xfer(d0, 8, r);
        xfer(d1, 8, r);
        if (!m_busy && m_wel) begin
            if (m_prot(a[18:0])) m_wel = 0;
            else begin
                q_exp.push_back('{er: 1'b0, a: a[18:0], d: d1});
                m_busy = 1;
            end
        end
        desel();
    endtask

    task automatic erase(input logic [23:0] a);
        logic [7:0] r;
        sel();
        xfer(8'hD8, 8, r);
        addr3(a);
        if (!m_busy && m_wel) begin
            if (m_prot(a[18:0])) m_wel = 0;
            else begin
                q_exp.push_back('{er: 1'b1, a: a[18:0], d: 8'h00});
                m_busy = 1;
            end
        end
        desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        sel();
        xfer(8'h01, 8, r);
        xfer(v, 8, r);
        if (!m_busy && m_wel) begin
            m_bp = v[4:2];
            m_busy = 1;
        end
        desel();
    endtask

    task automatic rdmem(input logic [23:0] a, input int n, input int extra,
                         input string req, input bit live);
        logic [7:0]  r;
        logic [7:0]  exp;
        logic [18:0] ai;
        sel();
        xfer(8'h03, 8, r);
        addr3(a);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, r);
            ai  = a[18:0] + 19'(i);
            exp = live ? pat(ai) : 8'h00;
            chk(r == exp, req, r, exp);
        end
        if (extra > 0) xfer(8'h00, extra, r);
        desel();
    endtask

    task automatic settle();
        repeat (BUSY + 20) @(negedge clk);
        if (m_busy) begin
            m_busy = 0;
            m_wel  = 0;
        end
    endtask

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        chk(do_o == 1'b0 && !mem_rd && !mem_prog && !mem_erase, "R13 reset outputs",
            {do_o, mem_rd, mem_prog, mem_erase}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        rdsr(1, "R1 R13 reset status");
        wren();
        rdsr(2, "R2 R4 status repeats after wren");
        wrdi();
        rdsr(1, "R4 wrdi clears latch");

        prog(24'h012345, 8'h11, 8'h22);
        rdsr(1, "R6 program without latch");

        wren();
        prog(24'h012345, 8'hA5, 8'h3C);
        rdsr(2, "R10 busy after program");
        erase(24'h020000);
        rdmem(24'h000100, 2, 0, "R11 read ignored while busy", 1'b0);
        settle();
        rdsr(1, "R10 busy end clears latch");

        wren();
        sel();
        xfer(8'hD8, 8, r);
        addr3(24'h051234);
        xfer(8'h00, 3, r);
        desel();
        rdsr(1, "R5 partial erase dropped");
        sel();
        xfer(8'h04, 8, r);
        xfer(8'h00, 4, r);
        desel();
        rdsr(1, "R5 partial wrdi dropped");

        erase(24'h051234);
        rdsr(1, "R8 R10 busy after erase");
        settle();

        wren();
        wrsr(8'h04);
        rdsr(1, "R9 busy during status write");
        settle();
        rdsr(1, "R9 protection code written");

        wren();
        prog(24'h070000, 8'h00, 8'h55);
        rdsr(1, "R12 code1 rejected clears latch");
        wren();
        prog(24'h06FFFF, 8'h00, 8'h66);
        settle();

        wren();
        wrsr(8'h08);
        settle();
        wren();
        prog(24'h060000, 8'h00, 8'h77);
        rdsr(1, "R12 code2 program rejected");
        wren();
        erase(24'h060000);
        rdsr(1, "R12 code2 erase rejected");
        wren();
        erase(24'h05FFFF);
        settle();

        wren();
        wrsr(8'h0C);
        settle();
        wren();
        prog(24'h040000, 8'h00, 8'h88);
        rdsr(1, "R12 code3 program rejected");
        wren();
        prog(24'h03FFFF, 8'h00, 8'h99);
        settle();

        wren();
        wrsr(8'h10);
        settle();
        wren();
        prog(24'h000000, 8'h00, 8'hAA);
        rdsr(1, "R12 code4 all protected");
        wren();
        erase(24'h000000);
        rdsr(1, "R12 code4 erase rejected");

        wren();
        wrsr(8'h00);
        settle();
        rdsr(1, "R9 protection cleared");

        rdmem(24'hFFFFFE, 3, 3, "R3 read wraps", 1'b1);
        rdsr(1, "R3 after read ended mid-byte");
        rdmem(24'h012340, 4, 0, "R3 sequential read", 1'b1);

        chk(q_exp.size() == 0, "R7 R8 missing strobes", q_exp.size(), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule